// File: doc/BRIEF.md
# Paired-Ring Memory Copy Engine

This block copies data from one region of system memory to another under the control of two descriptor rings that it reads from memory. The source ring supplies a source address and a byte length for each entry. The destination ring, indexed in lockstep with it, supplies the matching destination address. After an entry has been copied, the engine writes a completion flag back into that entry's destination descriptor. Software owns a producer index on the source ring and a reclaim index on the destination ring. The engine owns a consumer index on each ring.

Each descriptor is four 32-bit words, so it occupies 16 bytes. Word 0 is an address. Word 1 holds a 14-bit length at bits 29:16, and a done flag in the destination copy. The engine moves data one 32-bit word at a time over a single memory port. On that port a request is held until the memory acknowledges it, and read data arrives with the acknowledge. Software sets up the rings through a small register window, turns the engine on and off, and polls its busy flags. It can also clear the index state of either ring.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset every ring index reads 0, both entry counts read 64 and the global register reads 0. No memory request is raised.
- R2: The engine processes source entries from its consumer index (0x00C) up to, but not including, the producer index (0x008). It then stops with the consumer index equal to the producer index. Writing the producer index is what starts work.
- R3: Each entry copies ceil(length/4) 32-bit words from consecutive source words to consecutive destination words, in ascending address order. A length of 6 writes exactly two words.
- R4: When write-back is enabled (global bit 6), finishing an entry writes destination descriptor word 1 at descriptor address + 4. The value written has bit 31 set, the length in bits 29:16, and all other bits zero. With DONE_HI=0 the flag moves to bit 15.
- R5: The engine does not start an entry whose destination slot equals the destination reclaim index (0x108). It resumes once software moves that index on.
- R6: Ring indices advance as (index+1) & (count-1), so they wrap from count-1 to 0.
- R7: A new entry starts only while both enable bits (global bits 0 and 2) are set. Clearing them during an entry lets that entry finish. While an entry is in progress, both busy bits (global bits 1 and 3) read 1; when the engine is idle, both read 0.
- R8: Writing the reset register (0x208) with bit 0 set zeroes the source producer and consumer indices. Writing it with bit 16 set zeroes the destination ones. The other ring's indices are left unchanged.
- R9: With global bit 6 clear, no descriptor write-back occurs and destination descriptor word 1 is left untouched.
- R10: An entry of length 0 moves no data words but still completes, including its write-back.
- R11: A memory request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; completes the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The copy path is driven with lengths of 8, 6 and 0 bytes. These separate exact word copies, round-up of a partial final word, and the write-back-only path. A run of entries that wraps past the top of an 8-entry ring, with the reclaim index placed mid-run, separates correct index wrapping from a stall at the unreclaimed slot. A long 64-byte entry is disabled mid-flight, which separates the rule "finish the current entry" from stopping at once. The same entry also rules out starting the next one. The memory acknowledges irregularly throughout, so every request is also tried against back-pressure.

// File: rtl/ring_copy_engine.sv
module ring_copy_engine #(
  parameter int AW      = 32,
  parameter int IW      = 16,
  parameter int DEF_CNT = 64,
  parameter bit DONE_HI = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  localparam int DONE_BIT = DONE_HI ? 31 : 15;

  typedef enum logic [2:0] {S_IDLE, S_SA, S_SL, S_DA, S_CR, S_CW, S_WB} st_t;
  st_t st;

  logic [AW-1:0] s_base, d_base, src_ptr, dst_ptr;
  logic [IW-1:0] s_cnt, d_cnt, s_cidx, s_didx, d_cidx, d_didx;
  logic          s_en, d_en, wb_en, multi;
  logic [1:0]    burst;
  logic [13:0]   len;
  logic [15:0]   off;
  logic [31:0]   wbuf;

  wire [IW-1:0] s_mask  = s_cnt - 1'b1;
  wire [IW-1:0] d_mask  = d_cnt - 1'b1;
  wire [AW-1:0] sdesc   = s_base + AW'({s_didx, 4'b0000});
  wire [AW-1:0] ddesc   = d_base + AW'({d_didx, 4'b0000});
  wire          busy    = (st != S_IDLE);
  wire          go      = !busy && s_en && d_en && (s_didx != s_cidx) && (d_didx != d_cidx);
  wire          last_wd = ({2'b00, len} <= off + 16'd4);
  wire          fin     = mem_ack && ((st == S_WB) ||
                          (!wb_en && ((st == S_DA && len == 14'd0) || (st == S_CW && last_wd))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_base <= '0; d_base <= '0; s_cnt <= IW'(DEF_CNT); d_cnt <= IW'(DEF_CNT);
      s_cidx <= '0; s_didx <= '0; d_cidx <= '0; d_didx <= '0;
      s_en <= 1'b0; d_en <= 1'b0; wb_en <= 1'b0; multi <= 1'b0; burst <= '0;
    end else begin
      if (fin) begin
        s_didx <= (s_didx + 1'b1) & s_mask;
        d_didx <= (d_didx + 1'b1) & d_mask;
      end
      if (reg_we) begin
        case (reg_addr)
          12'h000: s_base <= AW'(reg_wdata);
          12'h004: s_cnt  <= reg_wdata[IW-1:0];
          12'h008: s_cidx <= reg_wdata[IW-1:0];
          12'h00C: s_didx <= reg_wdata[IW-1:0];
          12'h100: d_base <= AW'(reg_wdata);
          12'h104: d_cnt  <= reg_wdata[IW-1:0];
          12'h108: d_cidx <= reg_wdata[IW-1:0];
          12'h10C: d_didx <= reg_wdata[IW-1:0];
          12'h204: begin
            s_en <= reg_wdata[0]; d_en <= reg_wdata[2]; burst <= reg_wdata[5:4];
            wb_en <= reg_wdata[6]; multi <= reg_wdata[10];
          end
          12'h208: begin
            if (reg_wdata[0])  begin s_cidx <= '0; s_didx <= '0; end
            if (reg_wdata[16]) begin d_cidx <= '0; d_didx <= '0; end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; src_ptr <= '0; dst_ptr <= '0; len <= '0; off <= '0; wbuf <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) st <= S_SA;
        S_SA: if (mem_ack) begin src_ptr <= AW'(mem_rdata); st <= S_SL; end
        S_SL: if (mem_ack) begin len <= mem_rdata[29:16]; st <= S_DA; end
        S_DA: if (mem_ack) begin
          dst_ptr <= AW'(mem_rdata);
          off     <= '0;
          if (len != 14'd0) st <= S_CR;
          else              st <= wb_en ? S_WB : S_IDLE;
        end
        S_CR: if (mem_ack) begin wbuf <= mem_rdata; st <= S_CW; end
        S_CW: if (mem_ack) begin
          off <= off + 16'd4;
          if (!last_wd)   st <= S_CR;
          else            st <= wb_en ? S_WB : S_IDLE;
        end
        S_WB: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req = busy;

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = '0;
    mem_addr  = sdesc;
    case (st)
      S_SL: mem_addr = sdesc + AW'(4);
      S_DA: mem_addr = ddesc;
      S_CR: mem_addr = src_ptr + AW'(off);
      S_CW: begin mem_addr = dst_ptr + AW'(off); mem_we = 1'b1; mem_wdata = wbuf; end
      S_WB: begin
        mem_addr  = ddesc + AW'(4);
        mem_we    = 1'b1;
        mem_wdata = (32'(len) << 16) | (32'd1 << DONE_BIT);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      12'h000: reg_rdata = 32'(s_base);
      12'h004: reg_rdata = 32'(s_cnt);
      12'h008: reg_rdata = 32'(s_cidx);
      12'h00C: reg_rdata = 32'(s_didx);
      12'h100: reg_rdata = 32'(d_base);
      12'h104: reg_rdata = 32'(d_cnt);
      12'h108: reg_rdata = 32'(d_cidx);
      12'h10C: reg_rdata = 32'(d_didx);
      12'h204: reg_rdata = {21'b0, multi, 3'b000, wb_en, burst, busy, d_en, busy, s_en};
      default: reg_rdata = 32'h0;
    endcase
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(s_en && d_en));

  // R2
  start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(s_didx != s_cidx));

  // R5
  start_reclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(d_didx != d_cidx));

  // R6
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_didx != $past(s_didx) && !$past(reg_we)) |-> (s_didx == (($past(s_didx) + 1'b1) & $past(s_mask))));
endmodule

// File: tb/ring_copy_engine_bench.sv
module ring_copy_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic gate = 1'b1;
  int gcnt = 0;
  int n_cmp = 0, n_bad = 0;
  bit ended = 1'b0;
  logic [31:0] mem [0:4095];
  logic [31:0] exp_a[$], exp_d[$];
  logic p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;

  always #5 clk = ~clk;

  ring_copy_engine u_ring_copy_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  assign mem_ack   = mem_req & gate;
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(negedge clk) begin
    gcnt <= gcnt + 1;
    gate <= (gcnt % 3) != 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      // R11: a request not acknowledged last cycle must repeat unchanged
      if (p_req && !p_ack)
        chk(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata,
            "R11 request hold", mem_addr, p_addr);
      // R3 R4: every memory write matches the reference model in order
      if (mem_req && mem_we && mem_ack) begin
        if (exp_a.size() == 0) chk(1'b0, "R3/R4 unexpected write", mem_addr, 32'hx);
        else begin
          chk(mem_addr == exp_a[0] && mem_wdata == exp_d[0], "R3/R4 write", mem_wdata, exp_d[0]);
          void'(exp_a.pop_front());
          void'(exp_d.pop_front());
        end
        mem[mem_addr[13:2]] <= mem_wdata;
      end
    end
    p_req <= mem_req; p_ack <= mem_ack; p_we <= mem_we; p_addr <= mem_addr; p_wdata <= mem_wdata;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] sa(input int slot); return 32'h1000 + slot * 32'h100; endfunction
  function automatic logic [31:0] da(input int slot); return 32'h2000 + slot * 32'h100; endfunction

  task automatic make_entry(input int slot, input int len);
    mem[slot * 4]          = sa(slot);
    mem[slot * 4 + 1]      = 32'h4000_0000 | (32'(len) << 16);
    mem[256 + slot * 4]    = da(slot);
    mem[256 + slot * 4 + 1] = 32'h1234_5678;
    for (int w = 0; w < 17; w++) begin
      mem[(sa(slot) >> 2) + w] = 32'hA000_0000 + sa(slot) + 32'(w * 4);
      mem[(da(slot) >> 2) + w] = 32'hFFFF_FFFF;
    end
  endtask

  task automatic expect_entry(input int slot, input int len, input bit wb);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      exp_a.push_back(da(slot) + 32'(w * 4));
      exp_d.push_back(32'hA000_0000 + sa(slot) + 32'(w * 4));
    end
    if (wb) begin
      exp_a.push_back(32'h400 + 32'(slot * 16) + 32'd4);
      exp_d.push_back(32'h8000_0000 | (32'(len) << 16));
    end
  endtask

  task automatic wait_idx(input logic [11:0] a, input logic [31:0] tgt, input string req);
    logic [31:0] v = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(a, v);
      if (v == tgt) break;
    end
    chk(v == tgt, req, v, tgt);
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(mem_req == 1'b0, "R1 no request", 32'(mem_req), 0);
    rd(12'h004, v); chk(v == 64, "R1 count", v, 64);
    rd(12'h008, v); chk(v == 0, "R1 producer", v, 0);
    rd(12'h10C, v); chk(v == 0, "R1 dst consumer", v, 0);
    rd(12'h204, v); chk(v == 0, "R1 global", v, 0);

    wr(12'h000, 32'h0);   wr(12'h004, 8);
    wr(12'h100, 32'h400); wr(12'h104, 8);
    wr(12'h108, 7);
    wr(12'h204, 32'h465);
    rd(12'h204, v); chk(v == 32'h465, "R7 idle global", v, 32'h465);

    // R2 R3 R10: lengths 8, 6, 0
    make_entry(0, 8); make_entry(1, 6); make_entry(2, 0);
    expect_entry(0, 8, 1); expect_entry(1, 6, 1); expect_entry(2, 0, 1);
    wr(12'h008, 3);
    wait_idx(12'h00C, 3, "R2 consumer reaches producer");
    rd(12'h10C, v); chk(v == 3, "R2 dst consumer lockstep", v, 3);
    repeat (20) @(negedge clk);
    rd(12'h00C, v); chk(v == 3, "R2 stays stopped", v, 3);
    chk(mem[(da(1) >> 2) + 2] == 32'hFFFF_FFFF, "R3 no write past rounded length", mem[(da(1) >> 2) + 2], 32'hFFFF_FFFF);
    chk(mem[256 + 2 * 4 + 1] == 32'h8000_0000, "R10 zero-length write-back", mem[256 + 9], 32'h8000_0000);
    chk(mem[256 + 1 * 4 + 1] == 32'h8006_0000, "R4 done word", mem[256 + 5], 32'h8006_0000);

    // R5 R6: halt at unreclaimed slot 7, then wrap
    for (int s = 3; s < 8; s++) make_entry(s, 4 * s);
    for (int s = 3; s < 7; s++) expect_entry(s, 4 * s, 1);
    wr(12'h008, 0);
    wait_idx(12'h00C, 7, "R5 halt at reclaim index");
    repeat (40) @(negedge clk);
    rd(12'h00C, v); chk(v == 7, "R5 still halted", v, 7);
    rd(12'h204, v); chk(v[3:0] == 4'b0101, "R7 busy clear when halted", v, 32'h5);
    expect_entry(7, 28, 1);
    wr(12'h108, 2);
    wait_idx(12'h00C, 0, "R6 source index wraps");
    rd(12'h10C, v); chk(v == 0, "R6 dst index wraps", v, 0);

    // R9: write-back disabled
    wr(12'h204, 32'h425);
    make_entry(0, 4); expect_entry(0, 4, 0);
    wr(12'h008, 1);
    wait_idx(12'h00C, 1, "R9 entry completes");
    repeat (5) @(negedge clk);
    chk(mem[256 + 1] == 32'h1234_5678, "R9 descriptor untouched", mem[257], 32'h1234_5678);

    // R7: disabled engine does not start
    wr(12'h204, 32'h040);
    wr(12'h108, 6);
    make_entry(1, 8); make_entry(2, 64); make_entry(3, 12);
    wr(12'h008, 2);
    repeat (30) @(negedge clk);
    rd(12'h00C, v); chk(v == 1, "R7 no start while disabled", v, 1);
    expect_entry(1, 8, 1);
    wr(12'h204, 32'h465);
    wait_idx(12'h00C, 2, "R7 start after enable");
    expect_entry(2, 64, 1);
    wr(12'h008, 4);
    repeat (4) @(negedge clk);
    rd(12'h204, v); chk(v[3:0] == 4'b1111, "R7 both busy mid-entry", v, 32'hF);
    wr(12'h204, 32'h040);
    wait_idx(12'h00C, 3, "R7 in-flight entry finishes");
    repeat (40) @(negedge clk);
    rd(12'h00C, v); chk(v == 3, "R7 next entry not started", v, 3);
    rd(12'h204, v); chk(v[3:0] == 4'b0000, "R7 busy clear after finish", v, 0);
    expect_entry(3, 12, 1);
    wr(12'h204, 32'h465);
    wait_idx(12'h00C, 4, "R7 resumes");

    // R8: per-ring index reset
    wr(12'h208, 32'h1);
    rd(12'h008, v); chk(v == 0, "R8 source producer cleared", v, 0);
    rd(12'h00C, v); chk(v == 0, "R8 source consumer cleared", v, 0);
    rd(12'h10C, v); chk(v == 4, "R8 dst consumer kept", v, 4);
    rd(12'h108, v); chk(v == 6, "R8 dst reclaim kept", v, 6);
    wr(12'h208, 32'h10000);
    rd(12'h10C, v); chk(v == 0, "R8 dst consumer cleared", v, 0);
    rd(12'h108, v); chk(v == 0, "R8 dst reclaim cleared", v, 0);

    repeat (10) @(negedge clk);
    chk(exp_a.size() == 0, "R4 all expected writes seen", 32'(exp_a.size()), 0);
    summary();
  end
endmodule